// File: doc/BRIEF.md
# Shift Rotate Swap Unit

A 16-bit datapath unit that moves the bits of an operand by one or two positions, or exchanges its bytes, and produces updated sign, zero, carry and overflow flags. A 3-bit operation code selects one of eight functions, and a count bit selects one or two positions. Besides plain logical and arithmetic shifts, it offers forms that push bits out into the carry flag or rotate them through it. In the two-position carry forms the overflow flag acts as a second carry bit. The two-position swap instead copies the low byte into both halves.

The unit sits behind a register file. Each cycle it takes an operand together with the current carry and overflow flags, and one cycle later it presents the registered result, the four flag values, and one write enable per flag. The sign and zero flags are always written. Carry is written only by the carry forms, and overflow only by their two-position variants. When a flag is not written, its output repeats the incoming value, so a consumer can copy all four flags as they stand.

Top module: `srs_unit`

## Requirements
- R1: While rst_ni is low, every output is zero. Outputs are registered: the values presented after a rising clock edge belong to the inputs sampled at that edge.
- R2: Operation code 001 shifts left and fills with zeros. count_i=0 moves one position and count_i=1 moves two.
- R3: Operation code 100 shifts right and fills with zeros. Code 101 shifts right and fills every vacated bit with the original bit 15.
- R4: Operation code 011 shifts left and fills with zeros. C takes original bit 15. With count_i=1, O also takes original bit 14.
- R5: Operation code 010 rotates left through the flags. With count_i=0, bit 0 takes the incoming C. With count_i=1, bits 1:0 take {incoming O, incoming C}. C takes original bit 15, and with count_i=1 O takes original bit 14.
- R6: Operation code 111 shifts right arithmetically. C takes original bit 0. With count_i=1, O also takes original bit 1.
- R7: Operation code 110 rotates right through the flags. With count_i=0, bit 15 takes the incoming C. With count_i=1, bits 15:14 take {incoming C, incoming O}. C takes original bit 0, and with count_i=1 O takes original bit 1.
- R8: Operation code 000 with count_i=0 exchanges the two bytes. S is bit 7 of the result and Z is set when the whole result is zero.
- R9: Operation code 000 with count_i=1 places the low byte of the operand in both bytes. S and Z are taken from that low byte.
- R10: For every operation other than 000, S is bit 15 of the result and Z is set when the 16-bit result is zero.
- R11: Outside reset, the S and Z write enables are 1 for every operation. The C write enable is 1 only for codes 010, 011, 110 and 111. The O write enable is 1 only for those codes with count_i=1. When a flag is not written, its output equals the incoming flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code |
| count_i | input | 1 | 0: one position, 1: two positions |
| operand_i | input | 16 | Operand |
| c_i | input | 1 | Incoming carry flag |
| ov_i | input | 1 | Incoming overflow flag |
| result_o | output | 16 | Registered result |
| s_o | output | 1 | Sign flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| ov_o | output | 1 | Overflow flag |
| s_we_o | output | 1 | Sign flag write enable |
| z_we_o | output | 1 | Zero flag write enable |
| c_we_o | output | 1 | Carry flag write enable |
| ov_we_o | output | 1 | Overflow flag write enable |

## Verification
On every cycle the assertions check the relations between flags and result. Z must agree with the registered result. S must come from bit 15, or from bit 7 after a swap. A double swap must give matching halves. An arithmetic right shift must keep the sign. The overflow enable must imply the carry enable, and an unwritten flag must echo its input. The exact bit placement of each shift and rotate cannot be shown by these relations. That includes which original bit lands in C versus O, and the order of the fill bits. Only the bench's reference comparisons over directed edge patterns and random operands can show it.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [2:0] {
    OP_SWAP = 3'b000,
    OP_SLL  = 3'b001,
    OP_RLC  = 3'b010,
    OP_SLLC = 3'b011,
    OP_SLR  = 3'b100,
    OP_SAR  = 3'b101,
    OP_RRC  = 3'b110,
    OP_SARC = 3'b111
  } srs_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic c;
    logic o;
  } srs_flags_t;
endpackage

// File: rtl/srs_left.sv
module srs_left #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic         two_i,
  input  logic         rot_i,
  input  logic         c_i,
  input  logic         o_i,
  output logic [W-1:0] res_o
);
  logic [1:0] fill2;
  logic       fill1;

  always_comb begin
    fill1 = rot_i & c_i;
    fill2 = rot_i ? {o_i, c_i} : 2'b00;
    res_o = two_i ? {a_i[W-3:0], fill2} : {a_i[W-2:0], fill1};
  end
endmodule

// File: rtl/srs_right.sv
module srs_right #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic         two_i,
  input  logic         rot_i,
  input  logic         arith_i,
  input  logic         c_i,
  input  logic         o_i,
  output logic [W-1:0] res_o
);
  logic       sgn;
  logic [1:0] fill2;
  logic       fill1;

  always_comb begin
    sgn   = arith_i & a_i[W-1];
    fill1 = rot_i ? c_i : sgn;
    fill2 = rot_i ? {c_i, o_i} : {sgn, sgn};
    res_o = two_i ? {fill2, a_i[W-1:2]} : {fill1, a_i[W-1:1]};
  end
endmodule

// File: rtl/srs_swap.sv
module srs_swap #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic         two_i,
  output logic [W-1:0] res_o,
  output logic         sign_o
);
  localparam int HALF = W / 2;

  logic [HALF-1:0] lo, hi;

  always_comb begin
    lo     = a_i[HALF-1:0];
    hi     = a_i[W-1:HALF];
    res_o  = two_i ? {lo, lo} : {lo, hi};
    sign_o = res_o[HALF-1];
  end
endmodule

// File: rtl/srs_unit.sv
module srs_unit
  import srs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   op_i,
  input  logic         count_i,
  input  logic [W-1:0] operand_i,
  input  logic         c_i,
  input  logic         ov_i,
  output logic [W-1:0] result_o,
  output logic         s_o,
  output logic         z_o,
  output logic         c_o,
  output logic         ov_o,
  output logic         s_we_o,
  output logic         z_we_o,
  output logic         c_we_o,
  output logic         ov_we_o
);
  srs_op_e    op;
  logic [W-1:0] left_res, right_res, swap_res, res_d;
  logic       swap_sign;
  logic       carry_op, right_side;
  srs_flags_t flags_d, flags_q;
  logic       c_we_d, ov_we_d;

  assign op         = srs_op_e'(op_i);
  assign right_side = op_i[2];
  // codes 010, 011, 110, 111 share bit 1
  assign carry_op   = op_i[1];

  srs_left #(.W(W)) i_left (
    .a_i   (operand_i),
    .two_i (count_i),
    .rot_i (op == OP_RLC),
    .c_i   (c_i),
    .o_i   (ov_i),
    .res_o (left_res)
  );

  srs_right #(.W(W)) i_right (
    .a_i     (operand_i),
    .two_i   (count_i),
    .rot_i   (op == OP_RRC),
    .arith_i (op_i[0]),
    .c_i     (c_i),
    .o_i     (ov_i),
    .res_o   (right_res)
  );

  srs_swap #(.W(W)) i_swap (
    .a_i    (operand_i),
    .two_i  (count_i),
    .res_o  (swap_res),
    .sign_o (swap_sign)
  );

  always_comb begin
    if (op == OP_SWAP) begin
      res_d     = swap_res;
      flags_d.s = swap_sign;
    end else begin
      res_d     = right_side ? right_res : left_res;
      flags_d.s = res_d[W-1];
    end
    flags_d.z = (res_d == '0);
    flags_d.c = carry_op ? (right_side ? operand_i[0] : operand_i[W-1]) : c_i;
    flags_d.o = (carry_op & count_i) ?
                (right_side ? operand_i[1] : operand_i[W-2]) : ov_i;
    c_we_d    = carry_op;
    ov_we_d   = carry_op & count_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flags_q  <= '0;
      s_we_o   <= 1'b0;
      z_we_o   <= 1'b0;
      c_we_o   <= 1'b0;
      ov_we_o  <= 1'b0;
    end else begin
      result_o <= res_d;
      flags_q  <= flags_d;
      s_we_o   <= 1'b1;
      z_we_o   <= 1'b1;
      c_we_o   <= c_we_d;
      ov_we_o  <= ov_we_d;
    end
  end

  assign s_o  = flags_q.s;
  assign z_o  = flags_q.z;
  assign c_o  = flags_q.c;
  assign ov_o = flags_q.o;
endmodule

// File: rtl/srs_unit_chk.sv
module srs_unit_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   op_i,
  input logic         count_i,
  input logic [W-1:0] operand_i,
  input logic         c_i,
  input logic         ov_i,
  input logic [W-1:0] result_o,
  input logic         s_o,
  input logic         z_o,
  input logic         c_o,
  input logic         ov_o,
  input logic         s_we_o,
  input logic         z_we_o,
  input logic         c_we_o,
  input logic         ov_we_o
);
  localparam int HALF = W / 2;

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0 && !s_we_o && !z_we_o && !c_we_o && !ov_we_o));

  // R11
  sz_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (s_we_o && z_we_o));

  // R11
  ov_we_needs_c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_we_o |-> c_we_o);

  // R11
  c_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !c_we_o) |-> (c_o == $past(c_i)));

  // R11
  ov_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !ov_we_o) |-> (ov_o == $past(ov_i)));

  // R10
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_we_o |-> (z_o == (result_o == '0)));

  // R10
  sign_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) != 3'b000) |-> (s_o == result_o[W-1]));

  // R8
  swap_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) == 3'b000) |-> (s_o == result_o[HALF-1]));

  // R9
  dbl_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) == 3'b000 && $past(count_i))
      |-> (result_o[W-1:HALF] == result_o[HALF-1:0]));

  // R3
  sar_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) == 3'b101)
      |-> (result_o[W-1] == $past(operand_i[W-1])));
endmodule

bind srs_unit srs_unit_chk #(.W(W)) i_chk (.*);

// File: tb/test_srs_unit.sv
`timescale 1ns/1ps
module test_srs_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = '0;
  logic        count_i = 1'b0;
  logic [15:0] operand_i = '0;
  logic        c_i = 1'b0;
  logic        ov_i = 1'b0;
  logic [15:0] result_o;
  logic        s_o, z_o, c_o, ov_o;
  logic        s_we_o, z_we_o, c_we_o, ov_we_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk_i = ~clk_i;

  srs_unit i_srs_unit (
    .clk_i, .rst_ni, .op_i, .count_i, .operand_i, .c_i, .ov_i,
    .result_o, .s_o, .z_o, .c_o, .ov_o,
    .s_we_o, .z_we_o, .c_we_o, .ov_we_o
  );

  function automatic string req_of(input logic [2:0] op, input logic cnt);
    case (op)
      3'd0: return cnt ? "R9" : "R8";
      3'd1: return "R2";
      3'd2: return "R5";
      3'd3: return "R4";
      3'd4: return "R3";
      3'd5: return "R3";
      3'd6: return "R7";
      default: return "R6";
    endcase
  endfunction

  // expected packed as {result, s, z, c, o, s_we, z_we, c_we, o_we}
  function automatic logic [23:0] model(input logic [2:0] op, input logic cnt,
                                        input logic [15:0] a, input logic ci,
                                        input logic oi);
    logic [15:0] r;
    logic s, z, c, o, cw, ow;
    int n;
    n = cnt ? 2 : 1;
    c = ci; o = oi; cw = 0; ow = 0;
    case (op)
      3'd0: r = cnt ? {a[7:0], a[7:0]} : {a[7:0], a[15:8]};
      3'd1, 3'd3: r = a << n;
      3'd2: r = cnt ? ((a << 2) | {14'd0, oi, ci}) : ((a << 1) | {15'd0, ci});
      3'd4: r = a >> n;
      3'd5, 3'd7: r = 16'($signed(a) >>> n);
      default: r = cnt ? ((a >> 2) | {ci, oi, 14'd0}) : ((a >> 1) | {ci, 15'd0});
    endcase
    if (op inside {3'd2, 3'd3, 3'd6, 3'd7}) begin
      cw = 1;
      c  = (op[2]) ? a[0] : a[15];
      if (cnt) begin
        ow = 1;
        o  = (op[2]) ? a[1] : a[14];
      end
    end
    s = (op == 3'd0) ? r[7] : r[15];
    z = (r == 16'd0);
    return {r, s, z, c, o, 1'b1, 1'b1, cw, ow};
  endfunction

  function automatic logic [23:0] actual();
    return {result_o, s_o, z_o, c_o, ov_o, s_we_o, z_we_o, c_we_o, ov_we_o};
  endfunction

  task automatic compare(input logic [23:0] exp, input string tag);
    checks++;
    if (actual() !== exp) begin
      fails++;
      $display("FAIL %s: op=%0d cnt=%0d a=%h actual=%h expected=%h",
               tag, op_i, count_i, operand_i, actual(), exp);
    end
  endtask

  // called at a negedge; checks at the following negedge
  task automatic step(input logic [2:0] op, input logic cnt,
                      input logic [15:0] a, input logic ci, input logic oi);
    logic [23:0] exp;
    op_i = op; count_i = cnt; operand_i = a; c_i = ci; ov_i = oi;
    exp = model(op, cnt, a, ci, oi);
    @(posedge clk_i);
    @(negedge clk_i);
    compare(exp, $sformatf("%s R10 R11 R1", req_of(op, cnt)));
  endtask

  initial begin
    logic [15:0] pats [8];
    pats = '{16'h0000, 16'hFFFF, 16'h8001, 16'h4002,
             16'h00FF, 16'hFF00, 16'h0080, 16'h1234};
    @(negedge clk_i);
    op_i = 3'd3; operand_i = 16'hFFFF; c_i = 1; ov_i = 1; count_i = 1;
    @(negedge clk_i);
    @(negedge clk_i);
    // R1: reset holds outputs at zero
    compare(24'h0, "R1");
    rst_ni = 1'b1;
    for (int op = 0; op < 8; op++)
      for (int cnt = 0; cnt < 2; cnt++)
        for (int fl = 0; fl < 4; fl++)
          for (int p = 0; p < 8; p++)
            step(3'(op), cnt[0], pats[p], fl[0], fl[1]);
    for (int k = 0; k < 400; k++)
      step(3'($urandom), 1'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
    // R1: asynchronous reset clears mid-run
    #3 rst_ni = 1'b0;
    @(negedge clk_i);
    compare(24'h0, "R1");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule